// File: doc/BRIEF.md
# Dual-Width Arithmetic/Logic Unit with Condition Flags

This block is the arithmetic and logic stage of a small accumulator-style processor core. In each cycle it takes an operation code, a width select, two operands and the present flag byte. It computes an 8-bit result (on the low byte of the operands) or a 16-bit result. The result, the updated flag byte and a mask are registered. The mask names the flag bits that the operation wrote. Instruction decode, operand fetch and write-back are handled elsewhere; this block only calculates.

The flag byte holds eight bits. Only the half-carry, negative, zero, overflow and carry bits are ever produced here. The other three bits (stop disable, external-interrupt mask, interrupt mask) pass through unchanged. Each operation class has its own update rule:
- Logic operations clear overflow and keep carry.
- Clear writes a fixed pattern.
- Shifts and rotates load carry from the bit shifted out.

Top module: `cc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `flags_o` and `mask_o` become all zero on that edge.
- R2: Inputs sampled at a rising edge produce their result, flags and mask on that same edge, one cycle of latency. With `wide_i`=0 only `a_i[7:0]`/`b_i[7:0]` are used and `result_o[15:8]` is 0.
- R3: Flag byte bit positions are S=7, X=6, H=5, I=4, N=3, Z=2, V=1, C=0. Every bit of `flags_o` whose `mask_o` bit is 0 equals the same bit of `flags_i`, and mask bits 7, 6 and 4 are always 0.
- R4: When written, Z is 1 exactly when the active-width result is zero, and N equals result bit 7 (8-bit) or bit 15 (16-bit).
- R5: Add (code 0) and add-with-carry (code 1, adds C) write N Z V C, with C the unsigned carry out and V the signed overflow. H is written only in 8-bit mode and holds the carry out of bit 3.
- R6: Subtract (code 2) computes a−b, subtract-with-borrow (code 3) computes a−b−C, and negate (code 4) computes 0−a. All three write N Z V C, with C set on an unsigned borrow and V on signed overflow.
- R7: AND (5), OR (6), XOR (7) and move-b (8, result = b) write N and Z, clear V and leave C unchanged (mask 0x0E).
- R8: Complement (9) gives ~a with V=0 and C=1. Clear (10) gives result 0 with N=0, Z=1, V=0, C=0.
- R9: Increment (11) and decrement (12) write N Z V and leave C unchanged. V is set on a step across the signed limit.
- R10: Shift left (13) fills 0 and puts the old top bit in C. Logical shift right (14) fills the top with 0. Arithmetic shift right (15) keeps the sign bit. Both right shifts put the old bit 0 in C. All three set V = N xor C.
- R11: Rotate left (16) and rotate right (17) move through C (width+1 bits). C takes the bit that leaves, the entering bit is the old C, and V = N xor C.
- R12: Codes 18 to 31 return `a_i` (at the active width), mask 0, and `flags_o` equal to `flags_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| wide_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| flags_i | input | 8 | Present flag byte |
| result_o | output | 16 | Registered result |
| flags_o | output | 8 | Registered updated flag byte |
| mask_o | output | 8 | Registered mask of written flag bits |

## Verification
Every result, flag byte and mask is due exactly one rising edge after the inputs that caused it. The bench changes inputs on a falling edge and reads the outputs on the next falling edge, so each comparison sits half a period after the register that produced it. One stimulus is checked per cycle. Directed corners (signed limits, zero results, carry into rotates, borrow into subtract, undefined codes) come before a long random run over both widths.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  localparam int OP_W   = 5;
  localparam int FLAG_W = 8;

  // flag byte bit positions
  localparam int FL_C = 0;
  localparam int FL_V = 1;
  localparam int FL_Z = 2;
  localparam int FL_N = 3;
  localparam int FL_I = 4;
  localparam int FL_H = 5;
  localparam int FL_X = 6;
  localparam int FL_S = 7;

  localparam logic [FLAG_W-1:0] M_NZVC = 8'h0F;
  localparam logic [FLAG_W-1:0] M_NZV  = 8'h0E;
  localparam logic [FLAG_W-1:0] M_H    = 8'h20;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_NEG  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_MOVB = 5'd8,
    OP_COM  = 5'd9,
    OP_CLR  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_SHL  = 5'd13,
    OP_SHRL = 5'd14,
    OP_SHRA = 5'd15,
    OP_ROTL = 5'd16,
    OP_ROTR = 5'd17
  } alu_op_e;
endpackage

// File: rtl/cc_alu_add.sv
module cc_alu_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         c_msb,
  output logic         c_nib
);
  logic [W-1:0] lo;
  logic [1:0]   top;
  logic [4:0]   nib;

  // lower bits first, so the carry into the top bit is visible
  assign lo    = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, cin};
  assign top   = {1'b0, x[W-1]} + {1'b0, y[W-1]} + {1'b0, lo[W-1]};
  assign sum   = {top[0], lo[W-2:0]};
  assign cout  = top[1];
  assign c_msb = lo[W-1];
  assign nib   = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'b0, cin};
  assign c_nib = nib[4];
endmodule

// File: rtl/cc_alu_slice.sv
module cc_alu_slice
  import cc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         h,
  output logic         n,
  output logic         z,
  output logic         v,
  output logic         c
);
  logic [W-1:0] ax, ay, sum;
  logic         acin, cout, c_msb, c_nib;
  logic         is_sub;

  always_comb begin
    ax     = a;
    ay     = b;
    acin   = 1'b0;
    is_sub = 1'b0;
    unique case (op)
      OP_ADC: acin = c_in;
      OP_SUB: begin ay = ~b; acin = 1'b1;  is_sub = 1'b1; end
      OP_SBC: begin ay = ~b; acin = ~c_in; is_sub = 1'b1; end
      OP_NEG: begin ax = '0; ay = ~a; acin = 1'b1; is_sub = 1'b1; end
      OP_INC: begin ay = '0; acin = 1'b1; end
      OP_DEC: ay = '1;
      default: ;
    endcase
  end

  cc_alu_add #(.W(W)) u_add (
    .x(ax), .y(ay), .cin(acin),
    .sum(sum), .cout(cout), .c_msb(c_msb), .c_nib(c_nib)
  );

  always_comb begin
    res = a;
    v   = 1'b0;
    c   = c_in;
    h   = c_nib;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC: begin
        res = sum;
        v   = c_msb ^ cout;
        c   = is_sub ? ~cout : cout;
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_MOVB: res = b;
      OP_COM:  begin res = ~a; c = 1'b1; end
      OP_CLR:  begin res = '0; c = 1'b0; end
      OP_SHL:  begin res = {a[W-2:0], 1'b0};   c = a[W-1]; end
      OP_SHRL: begin res = {1'b0, a[W-1:1]};   c = a[0];   end
      OP_SHRA: begin res = {a[W-1], a[W-1:1]}; c = a[0];   end
      OP_ROTL: begin res = {a[W-2:0], c_in};   c = a[W-1]; end
      OP_ROTR: begin res = {c_in, a[W-1:1]};   c = a[0];   end
      default: ;
    endcase
    n = res[W-1];
    z = (res == '0);
    if (op inside {OP_SHL, OP_SHRL, OP_SHRA, OP_ROTL, OP_ROTR}) v = n ^ c;
  end
endmodule

// File: rtl/cc_alu_ctrl.sv
module cc_alu_ctrl
  import cc_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic              wide,
  output logic [FLAG_W-1:0] mask
);
  always_comb begin
    unique case (op)
      OP_ADD, OP_ADC:                          mask = wide ? M_NZVC : (M_NZVC | M_H);
      OP_SUB, OP_SBC, OP_NEG, OP_COM, OP_CLR:  mask = M_NZVC;
      OP_SHL, OP_SHRL, OP_SHRA, OP_ROTL, OP_ROTR: mask = M_NZVC;
      OP_AND, OP_OR, OP_XOR, OP_MOVB:          mask = M_NZV;
      OP_INC, OP_DEC:                          mask = M_NZV;
      default:                                 mask = '0;
    endcase
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int WIDE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic              wide_i,
  input  logic [WIDE_W-1:0] a_i,
  input  logic [WIDE_W-1:0] b_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [WIDE_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] mask_o
);
  localparam int NARROW_W = WIDE_W / 2;
  localparam int N_SLICE  = 2;

  alu_op_e           op_e;
  logic [WIDE_W-1:0] res_g [N_SLICE];
  logic [4:0]        fl_g  [N_SLICE];   // {h, n, z, v, c}
  logic [FLAG_W-1:0] mask, raw, next_flags;
  logic [4:0]        fl_sel;

  assign op_e = alu_op_e'(op_i);

  for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
    localparam int SW = (g == 0) ? NARROW_W : WIDE_W;
    logic [SW-1:0] r;
    cc_alu_slice #(.W(SW)) u_slice (
      .op(op_e), .a(a_i[SW-1:0]), .b(b_i[SW-1:0]), .c_in(flags_i[FL_C]),
      .res(r), .h(fl_g[g][4]), .n(fl_g[g][3]), .z(fl_g[g][2]),
      .v(fl_g[g][1]), .c(fl_g[g][0])
    );
    assign res_g[g] = WIDE_W'(r);
  end

  cc_alu_ctrl u_ctrl (.op(op_e), .wide(wide_i), .mask(mask));

  assign fl_sel     = fl_g[wide_i];
  assign raw        = {2'b00, fl_sel[4], 1'b0, fl_sel[3:0]};
  assign next_flags = (flags_i & ~mask) | (raw & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flags_o  <= '0;
      mask_o   <= '0;
    end else begin
      result_o <= res_g[wide_i];
      flags_o  <= next_flags;
      mask_o   <= mask;
    end
  end
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk
  import cc_alu_pkg::*;
#(
  parameter int WIDE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_i,
  input logic              wide_i,
  input logic [WIDE_W-1:0] a_i,
  input logic [WIDE_W-1:0] b_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [WIDE_W-1:0] result_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic [FLAG_W-1:0] mask_o
);
  localparam int NARROW_W = WIDE_W / 2;
  logic live;

  // set once a non-reset edge has loaded the output registers
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  a_r3_kept_bits: assert property (@(posedge clk) disable iff (rst)
    live |-> ((flags_o & ~mask_o) == ($past(flags_i) & ~mask_o)));

  a_r3_system_bits: assert property (@(posedge clk) disable iff (rst)
    live |-> (mask_o[FL_S] == 1'b0 && mask_o[FL_X] == 1'b0 && mask_o[FL_I] == 1'b0));

  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    (live && mask_o[FL_Z]) |-> (flags_o[FL_Z] == (result_o == '0)));

  a_r4_negative: assert property (@(posedge clk) disable iff (rst)
    (live && mask_o[FL_N]) |->
      (flags_o[FL_N] == ($past(wide_i) ? result_o[WIDE_W-1] : result_o[NARROW_W-1])));

  a_r2_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(wide_i)) |-> (result_o[WIDE_W-1:NARROW_W] == '0));

  a_r5_no_wide_half: assert property (@(posedge clk) disable iff (rst)
    (live && $past(wide_i)) |-> !mask_o[FL_H]);

  a_r7_logic_v: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_i) inside {5'd5, 5'd6, 5'd7, 5'd8}) |->
      (flags_o[FL_V] == 1'b0 && flags_o[FL_C] == $past(flags_i[FL_C])));

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_i) == 5'd10) |-> (flags_o[3:0] == 4'b0100 && result_o == '0));

  a_r11_rotl_in: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_i) == 5'd16) |-> (result_o[0] == $past(flags_i[FL_C])));

  a_r12_undefined: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_i) > 5'd17) |-> (mask_o == '0));
endmodule

bind cc_alu cc_alu_chk #(.WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .wide_i(wide_i), .a_i(a_i), .b_i(b_i),
  .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o), .mask_o(mask_o)
);

// File: tb/cc_alu_tb.sv
module cc_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic        wide_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [7:0]  flags_i = '0;
  logic [15:0] result_o;
  logic [7:0]  flags_o, mask_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_alu dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .wide_i(wide_i), .a_i(a_i), .b_i(b_i),
    .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o), .mask_o(mask_o)
  );

  function automatic string req_tag(int op);
    if (op <= 1)  return "R5";
    if (op <= 4)  return "R6";
    if (op <= 8)  return "R7";
    if (op <= 10) return "R8";
    if (op <= 12) return "R9";
    if (op <= 15) return "R10";
    if (op <= 17) return "R11";
    return "R12";
  endfunction

  // behavioural reference: returns {result, flags, mask}
  function automatic logic [31:0] model(int op, bit wide, int ain, int bin, logic [7:0] f);
    int  w, maxv, sgn, a, b, r, full, ci;
    bit  n, z, v, cc, h;
    logic [7:0] m, calc, outf;
    w = wide ? 16 : 8;
    maxv = (1 << w) - 1;
    sgn = 1 << (w - 1);
    a = ain & maxv;
    b = bin & maxv;
    ci = f[0];
    v = f[1]; cc = f[0]; h = f[5]; m = 8'h00; r = a;
    case (op)
      0, 1: begin
        full = a + b + ((op == 1) ? ci : 0);
        r = full & maxv; cc = full > maxv;
        v = ((~(a ^ b)) & (a ^ r) & sgn) != 0;
        h = ((a & 15) + (b & 15) + ((op == 1) ? ci : 0)) > 15;
        m = wide ? 8'h0F : 8'h2F;
      end
      2, 3: begin
        full = a - b - ((op == 3) ? ci : 0);
        r = full & maxv; cc = full < 0;
        v = ((a ^ b) & (a ^ r) & sgn) != 0; m = 8'h0F;
      end
      4:  begin r = (-a) & maxv; cc = a != 0; v = a == sgn; m = 8'h0F; end
      5:  begin r = a & b; v = 0; m = 8'h0E; end
      6:  begin r = a | b; v = 0; m = 8'h0E; end
      7:  begin r = a ^ b; v = 0; m = 8'h0E; end
      8:  begin r = b;     v = 0; m = 8'h0E; end
      9:  begin r = (~a) & maxv; v = 0; cc = 1; m = 8'h0F; end
      10: begin r = 0; v = 0; cc = 0; m = 8'h0F; end
      11: begin r = (a + 1) & maxv; v = a == sgn - 1; m = 8'h0E; end
      12: begin r = (a - 1) & maxv; v = a == sgn;     m = 8'h0E; end
      13: begin cc = (a & sgn) != 0; r = (a << 1) & maxv; m = 8'h0F; end
      14: begin cc = a & 1; r = a >> 1; m = 8'h0F; end
      15: begin cc = a & 1; r = (a >> 1) | (a & sgn); m = 8'h0F; end
      16: begin cc = (a & sgn) != 0; r = ((a << 1) | ci) & maxv; m = 8'h0F; end
      17: begin cc = a & 1; r = (a >> 1) | (ci ? sgn : 0); m = 8'h0F; end
      default: begin r = a; m = 8'h00; end
    endcase
    n = (r & sgn) != 0;
    z = (r == 0);
    if (op >= 13 && op <= 17) v = n ^ cc;
    calc = {f[7:6], h, f[4], n, z, v, cc};
    outf = (f & ~m) | (calc & m);
    return {r[15:0], outf, m};
  endfunction

  task automatic apply(int op, bit wide, int a, int b, logic [7:0] f);
    logic [31:0] exp_v;
    @(negedge clk);
    op_i = op[4:0]; wide_i = wide; a_i = a[15:0]; b_i = b[15:0]; flags_i = f;
    exp_v = model(op, wide, a, b, f);
    @(negedge clk);
    checks++;
    if ({result_o, flags_o, mask_o} !== exp_v) begin
      errors++;
      $display("FAIL %s (R2 R3 R4) op=%0d wide=%0d a=%h b=%h f=%h: got res=%h fl=%h mk=%h exp res=%h fl=%h mk=%h",
               req_tag(op), op, wide, a[15:0], b[15:0], f, result_o, flags_o, mask_o,
               exp_v[31:16], exp_v[15:8], exp_v[7:0]);
    end
  endtask

  initial begin
    // R1: reset with busy inputs
    op_i = 5'd0; wide_i = 1'b1; a_i = 16'h1234; b_i = 16'h4321; flags_i = 8'hFF;
    repeat (3) @(negedge clk);
    checks++;
    if (result_o !== 16'h0 || flags_o !== 8'h0 || mask_o !== 8'h0) begin
      errors++;
      $display("FAIL R1 reset: got res=%h fl=%h mk=%h exp 0 0 0", result_o, flags_o, mask_o);
    end
    rst = 1'b0;

    // R5 corners
    apply(0, 0, 'h7F, 'h01, 8'h00);
    apply(0, 0, 'hFF, 'h01, 8'h00);
    apply(1, 0, 'h0F, 'h00, 8'h01);
    apply(0, 1, 'h7FFF, 'h0001, 8'h20);
    apply(1, 1, 'hFFFF, 'h0000, 8'h01);
    // R6 corners
    apply(2, 0, 'h00, 'h01, 8'h00);
    apply(2, 0, 'h80, 'h01, 8'h00);
    apply(3, 0, 'h10, 'h10, 8'h01);
    apply(3, 1, 'h0000, 'h0000, 8'h01);
    apply(4, 0, 'h00, 'h00, 8'h01);
    apply(4, 0, 'h80, 'h00, 8'h00);
    apply(4, 1, 'h8000, 'h0000, 8'h00);
    // R7: C kept in both states
    apply(5, 0, 'hF0, 'h3C, 8'h03);
    apply(6, 1, 'h8000, 'h0001, 8'h02);
    apply(7, 0, 'hAA, 'hAA, 8'hD1);
    apply(8, 1, 'h0000, 'h0000, 8'h01);
    // R8
    apply(9, 0, 'hFF, 'h00, 8'h00);
    apply(10, 1, 'hFFFF, 'hFFFF, 8'hFB);
    // R9
    apply(11, 0, 'h7F, 'h00, 8'h01);
    apply(12, 0, 'h80, 'h00, 8'h00);
    apply(12, 1, 'h0000, 'h0000, 8'h01);
    // R10
    apply(13, 0, 'h80, 'h00, 8'h00);
    apply(14, 1, 'h8001, 'h00, 8'h00);
    apply(15, 0, 'h81, 'h00, 8'h00);
    // R11
    apply(16, 0, 'h40, 'h00, 8'h01);
    apply(17, 1, 'h0001, 'h00, 8'h00);
    apply(17, 0, 'h00, 'h00, 8'h01);
    // R12
    apply(18, 0, 'hA5C3, 'h00, 8'hFF);
    apply(31, 1, 'h1234, 'h00, 8'h5A);

    // random run, both widths
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = (i % 50 == 49) ? int'($urandom_range(18, 31)) : int'($urandom_range(0, 17));
      apply(op, $urandom_range(0, 1) == 1, int'($urandom & 16'hFFFF),
            int'($urandom & 16'hFFFF), 8'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule